// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block runs single read and write accesses on an external asynchronous, memory-mapped device, for example a storage card wired as a plain register-addressed disk interface. A host pulses a request with an address, a direction, a width choice and write data. The block then produces a chip-select window, a read or write strobe inside that window, a held address and the data-bus direction. It returns a one-clock acknowledge together with the captured read data.

Timing comes from three compactly coded fields: setup, strobe pulse and total cycle. Each field has a high-weight bit, so short values and long values both fit in a few bits. When the coded cycle is shorter than setup plus pulse, the access is lengthened to setup plus pulse. An optional ready input can hold the strobe active while the device is slow. After a read, a data-float count of idle clocks can be inserted so the device has time to release the shared data bus before the next access. Configuration and request fields are latched when the request is accepted. Requests that arrive while an access or its float period is in progress are dropped.

Top module: `asyncmem_cycle_gen`

## Requirements
- R1: In reset, and on the first cycles after it, `mem_cs_n`, `mem_rd_n` and `mem_wr_n` are high, and `ack`, `mem_doe` and `rdata` are zero. A synchronous reset during an access returns all of these to that state.
- R2: The setup field decodes to 128 × bit5 + bits[4:0] clocks. The strobe goes low that many cycles after `mem_cs_n` goes low.
- R3: The pulse field decodes to 256 × bit6 + bits[5:0] clocks. When not stretched, the strobe stays low for exactly that many cycles. A pulse of zero gives no strobe.
- R4: The cycle field decodes to 256 × bits[8:7] + bits[6:0] clocks. `mem_cs_n` stays low for the larger of that value and setup + pulse, and for at least one cycle. Every strobe cycle lies inside the chip-select window.
- R5: `ack` is high for exactly one cycle, namely the cycle right after the last chip-select cycle. `mem_cs_n` is high while `ack` is high.
- R6: A read (`req_write`=0) pulses only `mem_rd_n`. A write (`req_write`=1) pulses only `mem_wr_n`. The two are never low together.
- R7: Read data is sampled from `mem_din` on the clock edge that ends the strobe. It is presented on `rdata` while `ack` is high.
- R8: With `cfg_rdy_en`=1, every clock edge at which the strobe is low and `mem_rdy` is low adds one cycle to both the strobe and chip select. With `cfg_rdy_en`=0, `mem_rdy` has no effect.
- R9: After a read with float count F (0–15), a request held high from the acknowledge cycle makes `mem_cs_n` fall F+1 cycles after the acknowledge cycle. After a write, the float count is not applied and the gap is 1 cycle.
- R10: During a write, `mem_doe` is high and `mem_dout` holds the write data for every chip-select cycle. `mem_doe` is low outside write accesses.
- R11: With `req_wide`=0 (8-bit), `mem_wide` is 0, the upper byte of `mem_dout` is zero and the upper byte of `rdata` is zero. With `req_wide`=1 (16-bit), all 16 bits pass and `mem_wide` is 1.
- R12: A request, together with any change of request or configuration inputs, has no effect while an access or float period is in progress. No extra chip-select window and no extra `ack` follow from it.
- R13: `mem_addr` holds the address latched at acceptance for the whole chip-select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_setup | input | 6 | Coded setup time |
| cfg_pulse | input | 7 | Coded strobe pulse time |
| cfg_cycle | input | 9 | Coded total cycle time |
| cfg_float | input | 4 | Idle clocks after a read |
| cfg_rdy_en | input | 1 | Enable strobe stretching by `mem_rdy` |
| ack | output | 1 | One-clock access completion |
| rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Device chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Device address |
| mem_dout | output | DATA_W | Data driven toward the device |
| mem_doe | output | 1 | Data output enable (write direction) |
| mem_wide | output | 1 | Current access uses the 16-bit bus |
| mem_din | input | DATA_W | Data returned by the device |
| mem_rdy | input | 1 | Device ready, low stretches the strobe |

## Verification
The bench builds the block with its default parameters, a 12-bit address and a 16-bit data bus. Under these values, every decode range of all three timing fields can be reached in a short run. This includes the extremes of 159 setup clocks, 319 pulse clocks and an 895-clock cycle, as well as cycles that the setup-plus-pulse rule lengthens. The 16-bit bus lets the bench observe the 8-bit mode's upper-lane masking in both directions. The float count is also exercised at 0, 4, 5 and 6, so the read-only float gap can be measured against writes.

// File: rtl/asyncmem_pkg.sv
// Shared widths, field decoders and state type for the asynchronous
// memory strobe sequencer. The field widths are fixed by the coding
// scheme; the counter width covers the largest decoded cycle (895).
package asyncmem_pkg;

    localparam int SETUP_FW = 6;
    localparam int PULSE_FW = 7;
    localparam int CYCLE_FW = 9;
    localparam int FLOAT_FW = 4;
    localparam int CNT_W    = 10;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } phase_t;

    // Setup: bit5 weighs 128, bits[4:0] are linear.
    function automatic cnt_t decode_setup(input logic [SETUP_FW-1:0] f);
        return cnt_t'({f[5], 7'b0}) + cnt_t'(f[4:0]);
    endfunction

    // Pulse: bit6 weighs 256, bits[5:0] are linear.
    function automatic cnt_t decode_pulse(input logic [PULSE_FW-1:0] f);
        return cnt_t'({f[6], 8'b0}) + cnt_t'(f[5:0]);
    endfunction

    // Cycle: bits[8:7] weigh 256 each step, bits[6:0] are linear.
    function automatic cnt_t decode_cycle(input logic [CYCLE_FW-1:0] f);
        return cnt_t'({f[8:7], 8'b0}) + cnt_t'(f[6:0]);
    endfunction

endpackage

// File: rtl/asyncmem_timing.sv
// Turns the latched coded timing fields into the cycle indices used by the
// sequencer: strobe start, strobe end (exclusive) and the last index of the
// chip-select window. Assumes the fields are stable for the whole access.
// Purely combinational.
module asyncmem_timing
    import asyncmem_pkg::*;
(
    input  logic [SETUP_FW-1:0] setup_f,
    input  logic [PULSE_FW-1:0] pulse_f,
    input  logic [CYCLE_FW-1:0] cycle_f,
    output cnt_t                strobe_on,
    output cnt_t                strobe_off,
    output cnt_t                last_t
);

    cnt_t setup_len;
    cnt_t pulse_len;
    cnt_t cycle_len;
    cnt_t busy_len;
    cnt_t eff_len;

    // Decode the three fields and lengthen the cycle to cover setup + pulse.
    always_comb begin
        setup_len = decode_setup(setup_f);
        pulse_len = decode_pulse(pulse_f);
        cycle_len = decode_cycle(cycle_f);
        busy_len  = setup_len + pulse_len;
        eff_len   = (cycle_len > busy_len) ? cycle_len : busy_len;
    end

    assign strobe_on  = setup_len;
    assign strobe_off = busy_len;
    assign last_t     = (eff_len == '0) ? '0 : eff_len - cnt_t'(1);

endmodule

// File: rtl/asyncmem_seq.sv
// Access sequencer: idle / access / float phases, the in-access cycle
// counter, ready stretching, the read-capture strobe and the acknowledge.
// Assumes the timing indices and attributes come from registers that were
// loaded on the cycle the request was accepted.
module asyncmem_seq
    import asyncmem_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  cnt_t                strobe_on,
    input  cnt_t                strobe_off,
    input  cnt_t                last_t,
    input  logic                is_read,
    input  logic                rdy_en,
    input  logic                mem_rdy,
    input  logic [FLOAT_FW-1:0] float_len,
    output logic                accept,
    output logic                access,
    output logic                strobe_act,
    output logic                capture,
    output logic                ack
);

    phase_t              phase_q;
    cnt_t                t_q;
    logic [FLOAT_FW-1:0] f_q;
    logic                ack_q;
    logic                stall;
    logic                last_beat;

    assign access     = (phase_q == ST_ACCESS);
    assign accept     = (phase_q == ST_IDLE) && req_valid;
    assign strobe_act = access && (t_q >= strobe_on) && (t_q < strobe_off);
    assign stall      = strobe_act && rdy_en && !mem_rdy;
    assign capture    = strobe_act && !stall && ((t_q + cnt_t'(1)) == strobe_off);
    assign last_beat  = access && !stall && (t_q == last_t);
    assign ack        = ack_q;

    // Phase machine, cycle counter, float counter and acknowledge register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ST_IDLE;
            t_q     <= '0;
            f_q     <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= last_beat;
            unique case (phase_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        phase_q <= ST_ACCESS;
                        t_q     <= '0;
                    end
                end
                ST_ACCESS: begin
                    if (last_beat) begin
                        if (is_read && (float_len != '0)) begin
                            phase_q <= ST_FLOAT;
                            f_q     <= '0;
                        end else begin
                            phase_q <= ST_IDLE;
                        end
                    end else if (!stall) begin
                        t_q <= t_q + cnt_t'(1);
                    end
                end
                ST_FLOAT: begin
                    if ((f_q + FLOAT_FW'(1)) == float_len) phase_q <= ST_IDLE;
                    else f_q <= f_q + FLOAT_FW'(1);
                end
                default: phase_q <= ST_IDLE;
            endcase
        end
    end

    // R5: the acknowledge never lasts two cycles.
    a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);

    // R8: a stalled strobe is still active on the next cycle.
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> strobe_act);

    // R12: the float period never leads straight into a new access.
    a_r12_float_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_FLOAT) |=> (phase_q != ST_ACCESS));

    // R7: after the capture edge the strobe is released.
    a_r7_capture_releases: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !strobe_act);

    // R4: the window never closes before the strobe has finished.
    a_r4_window_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> ((t_q + cnt_t'(1)) >= strobe_off));

endmodule

// File: rtl/asyncmem_xfer_regs.sv
// Request and configuration holding registers plus read-data capture.
// Everything is loaded on the accept cycle and held until the next accept,
// so host inputs may change freely during an access. The 8-bit mode masks
// the upper half of the data path in both directions.
module asyncmem_xfer_regs
    import asyncmem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                capture,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [SETUP_FW-1:0] cfg_setup,
    input  logic [PULSE_FW-1:0] cfg_pulse,
    input  logic [CYCLE_FW-1:0] cfg_cycle,
    input  logic [FLOAT_FW-1:0] cfg_float,
    input  logic                cfg_rdy_en,
    input  logic [DATA_W-1:0]   mem_din,
    output logic                write_q,
    output logic                wide_q,
    output logic                rdy_en_q,
    output logic [FLOAT_FW-1:0] float_q,
    output logic [SETUP_FW-1:0] setup_q,
    output logic [PULSE_FW-1:0] pulse_q,
    output logic [CYCLE_FW-1:0] cycle_q,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [DATA_W-1:0]   dout,
    output logic [DATA_W-1:0]   rdata
);

    localparam int NARROW_W = DATA_W / 2;

    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] lane_keep;

    assign lane_keep = wide_q ? {DATA_W{1'b1}}
                              : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    assign dout      = wdata_q & lane_keep;
    assign rdata     = rdata_q;

    // Latch the request and its timing on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q  <= 1'b0;
            wide_q   <= 1'b0;
            rdy_en_q <= 1'b0;
            float_q  <= '0;
            setup_q  <= '0;
            pulse_q  <= '0;
            cycle_q  <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            write_q  <= req_write;
            wide_q   <= req_wide;
            rdy_en_q <= cfg_rdy_en;
            float_q  <= cfg_float;
            setup_q  <= cfg_setup;
            pulse_q  <= cfg_pulse;
            cycle_q  <= cfg_cycle;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    // Sample the device data on the edge that ends a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (capture && !write_q) rdata_q <= mem_din & lane_keep;
    end

endmodule

// File: rtl/asyncmem_cycle_gen.sv
// Top of the asynchronous memory strobe sequencer. Joins the holding
// registers, the field decoder and the sequencer, and forms the active-low
// device controls. Chip select has zero setup and spans the whole
// (possibly lengthened) cycle. Assumes one outstanding access at a time.
module asyncmem_cycle_gen
    import asyncmem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [SETUP_FW-1:0] cfg_setup,
    input  logic [PULSE_FW-1:0] cfg_pulse,
    input  logic [CYCLE_FW-1:0] cfg_cycle,
    input  logic [FLOAT_FW-1:0] cfg_float,
    input  logic                cfg_rdy_en,
    output logic                ack,
    output logic [DATA_W-1:0]   rdata,
    output logic                mem_cs_n,
    output logic                mem_rd_n,
    output logic                mem_wr_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dout,
    output logic                mem_doe,
    output logic                mem_wide,
    input  logic [DATA_W-1:0]   mem_din,
    input  logic                mem_rdy
);

    logic                accept;
    logic                capture;
    logic                access;
    logic                strobe_act;
    logic                write_q;
    logic                wide_q;
    logic                rdy_en_q;
    logic [FLOAT_FW-1:0] float_q;
    logic [SETUP_FW-1:0] setup_q;
    logic [PULSE_FW-1:0] pulse_q;
    logic [CYCLE_FW-1:0] cycle_q;
    cnt_t                strobe_on;
    cnt_t                strobe_off;
    cnt_t                last_t;

    asyncmem_xfer_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_write  (req_write),
        .req_wide   (req_wide),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cfg_setup  (cfg_setup),
        .cfg_pulse  (cfg_pulse),
        .cfg_cycle  (cfg_cycle),
        .cfg_float  (cfg_float),
        .cfg_rdy_en (cfg_rdy_en),
        .mem_din    (mem_din),
        .write_q    (write_q),
        .wide_q     (wide_q),
        .rdy_en_q   (rdy_en_q),
        .float_q    (float_q),
        .setup_q    (setup_q),
        .pulse_q    (pulse_q),
        .cycle_q    (cycle_q),
        .addr_q     (mem_addr),
        .dout       (mem_dout),
        .rdata      (rdata)
    );

    asyncmem_timing u_timing (
        .setup_f    (setup_q),
        .pulse_f    (pulse_q),
        .cycle_f    (cycle_q),
        .strobe_on  (strobe_on),
        .strobe_off (strobe_off),
        .last_t     (last_t)
    );

    asyncmem_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .strobe_on  (strobe_on),
        .strobe_off (strobe_off),
        .last_t     (last_t),
        .is_read    (!write_q),
        .rdy_en     (rdy_en_q),
        .mem_rdy    (mem_rdy),
        .float_len  (float_q),
        .accept     (accept),
        .access     (access),
        .strobe_act (strobe_act),
        .capture    (capture),
        .ack        (ack)
    );

    // Device control pins, active low, derived from sequencer state.
    always_comb begin
        mem_cs_n = !access;
        mem_rd_n = !(strobe_act && !write_q);
        mem_wr_n = !(strobe_act && write_q);
        mem_doe  = access && write_q;
        mem_wide = wide_q;
    end

    // R4: a strobe only appears inside the chip-select window.
    a_r4_cs_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> !mem_cs_n);

    // R6: read and write strobes are never low together.
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    // R10: the data bus is driven only inside a chip-select window.
    a_r10_doe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> (!mem_cs_n && mem_rd_n));

    // R5: acknowledge only after chip select has been released.
    a_r5_ack_outside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> mem_cs_n);

    // R13: the address is held while chip select stays low.
    a_r13_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/asyncmem_cycle_gen_tb.sv
module asyncmem_cycle_gen_tb;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [5:0]  su;
        logic [6:0]  pu;
        logic [8:0]  cy;
        logic [3:0]  fl;
        logic        ren;
        logic [3:0]  rel;
        logic        poke;
        logic [11:0] addr;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 6'h02, 7'h03, 9'h008, 4'd0, 1'b0, 4'd0, 1'b0, 12'h0A1, 16'hA55A},
        '{1'b1, 1'b1, 6'h00, 7'h01, 9'h001, 4'd0, 1'b0, 4'd0, 1'b0, 12'h0F0, 16'h1234},
        '{1'b0, 1'b1, 6'h21, 7'h04, 9'h00A, 4'd0, 1'b0, 4'd0, 1'b1, 12'h123, 16'hBEEF},
        '{1'b1, 1'b0, 6'h03, 7'h41, 9'h1FF, 4'd0, 1'b0, 4'd0, 1'b0, 12'hABC, 16'h5A3C},
        '{1'b0, 1'b1, 6'h01, 7'h02, 9'h085, 4'd5, 1'b0, 4'd0, 1'b0, 12'h555, 16'h0F0F},
        '{1'b1, 1'b1, 6'h00, 7'h00, 9'h000, 4'd0, 1'b0, 4'd0, 1'b0, 12'h001, 16'hFFFF},
        '{1'b0, 1'b1, 6'h05, 7'h3F, 9'h07F, 4'd0, 1'b0, 4'd0, 1'b1, 12'h7FF, 16'h8001},
        '{1'b1, 1'b1, 6'h3F, 7'h7F, 9'h100, 4'd0, 1'b0, 4'd0, 1'b0, 12'hFFF, 16'h6BD3},
        '{1'b0, 1'b1, 6'h01, 7'h02, 9'h004, 4'd0, 1'b1, 4'd4, 1'b0, 12'h010, 16'hC3C3},
        '{1'b0, 1'b0, 6'h01, 7'h02, 9'h004, 4'd0, 1'b0, 4'd4, 1'b0, 12'h020, 16'h9A9A},
        '{1'b1, 1'b1, 6'h02, 7'h02, 9'h003, 4'd0, 1'b1, 4'd2, 1'b0, 12'h030, 16'h7E81}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_wide = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [5:0]        cfg_setup = '0;
    logic [6:0]        cfg_pulse = '0;
    logic [8:0]        cfg_cycle = '0;
    logic [3:0]        cfg_float = '0;
    logic              cfg_rdy_en = 1'b0;
    logic              ack;
    logic [DATA_W-1:0] rdata;
    logic              mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, mem_wide;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dout;
    logic [DATA_W-1:0] mem_din = '0;
    logic              mem_rdy = 1'b1;

    int n_checks = 0;
    int n_fails  = 0;

    asyncmem_cycle_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle),
        .cfg_float(cfg_float), .cfg_rdy_en(cfg_rdy_en), .ack(ack), .rdata(rdata),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_wide(mem_wide), .mem_din(mem_din), .mem_rdy(mem_rdy)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int dec_s(input logic [5:0] f);
        return (f[5] ? 128 : 0) + int'(f[4:0]);
    endfunction
    function automatic int dec_p(input logic [6:0] f);
        return (f[6] ? 256 : 0) + int'(f[5:0]);
    endfunction
    function automatic int dec_c(input logic [8:0] f);
        return 256 * int'(f[8:7]) + int'(f[6:0]);
    endfunction

    // One access from the table; measures the window, strobe and ack.
    task automatic run_vec(input vec_t v);
        int s, p, c, stall, cs_cnt, st_first, st_cnt;
        bit got_ack, kind_bad, addr_bad, doe_bad, dout_bad, wide_bad, post_bad;
        logic [15:0] exp_d;
        s = dec_s(v.su);
        p = dec_p(v.pu);
        c = dec_c(v.cy);
        if (s + p > c) c = s + p;
        if (c == 0) c = 1;
        stall = (v.rel != 0 && v.ren && p > 0) ? int'(v.rel) - 1 : 0;
        exp_d = v.wide ? v.data : {8'h00, v.data[7:0]};
        @(negedge clk);
        req_write = v.wr; req_wide = v.wide; req_addr = v.addr; req_wdata = v.data;
        cfg_setup = v.su; cfg_pulse = v.pu; cfg_cycle = v.cy; cfg_float = v.fl;
        cfg_rdy_en = v.ren; mem_din = v.data; mem_rdy = (v.rel == 0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cs_cnt = 0; st_first = -1; st_cnt = 0; got_ack = 0;
        kind_bad = 0; addr_bad = 0; doe_bad = 0; dout_bad = 0; wide_bad = 0;
        for (int k = 0; k < 1200 && !got_ack; k++) begin
            if (ack) begin
                got_ack = 1;
            end else begin
                if (!mem_cs_n) begin
                    if (!mem_rd_n || !mem_wr_n) begin
                        if (st_first < 0) st_first = cs_cnt;
                        st_cnt++;
                        if (v.wr ? (mem_wr_n || !mem_rd_n) : (mem_rd_n || !mem_wr_n)) kind_bad = 1;
                        if (v.rel != 0 && st_cnt == int'(v.rel)) mem_rdy = 1'b1;
                    end
                    if (mem_addr != v.addr) addr_bad = 1;
                    if (mem_doe != v.wr) doe_bad = 1;
                    if (v.wr && mem_dout != exp_d) dout_bad = 1;
                    if (mem_wide != v.wide) wide_bad = 1;
                    cs_cnt++;
                end else if (mem_doe) begin
                    doe_bad = 1;
                end
                if (v.poke && cs_cnt == 1) begin
                    req_valid = 1'b1; req_addr = ~v.addr; cfg_pulse = 7'h00;
                end else begin
                    req_valid = 1'b0;
                end
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        mem_rdy = 1'b1;
        chk(got_ack, "R5 ack arrives", int'(got_ack), 1);
        chk(mem_cs_n, "R5 cs high during ack", int'(mem_cs_n), 1);
        chk(cs_cnt == c + stall, "R4/R8 chip-select cycles", cs_cnt, c + stall);
        if (p > 0) chk(st_first == s, "R2 strobe start offset", st_first, s);
        chk(st_cnt == p + stall, "R3/R8 strobe cycles", st_cnt, p + stall);
        chk(!kind_bad, "R6 strobe matches direction", int'(kind_bad), 0);
        chk(!addr_bad, "R13 address held", int'(addr_bad), 0);
        chk(!doe_bad, "R10 output enable", int'(doe_bad), 0);
        chk(!wide_bad, "R11 width flag", int'(wide_bad), 0);
        if (v.wr) chk(!dout_bad, "R10/R11 write data", int'(dout_bad), 0);
        else      chk(rdata == exp_d, "R7/R11 read data", int'(rdata), int'(exp_d));
        post_bad = 0;
        for (int k = 0; k <= int'(v.fl); k++) begin
            @(negedge clk);
            if (!mem_cs_n || ack) post_bad = 1;
        end
        if (v.poke) chk(!post_bad, "R12 request during access ignored", int'(post_bad), 0);
        else        chk(!post_bad, "R5 no repeat ack", int'(post_bad), 0);
        @(negedge clk);
    endtask

    // Request held from the ack cycle; measures cycles until cs falls again.
    task automatic gap_test(input logic wr, input logic [3:0] fl, input int exp_gap, input string tag);
        int n;
        bit seen;
        @(negedge clk);
        req_write = wr; req_wide = 1'b1; cfg_setup = 6'h00; cfg_pulse = 7'h01;
        cfg_cycle = 9'h002; cfg_float = fl; cfg_rdy_en = 1'b0; mem_rdy = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        for (int k = 0; k < 100 && !seen; k++) begin
            if (ack) seen = 1;
            else @(negedge clk);
        end
        req_valid = 1'b1;
        n = 0; seen = 0;
        for (int k = 0; k < 100 && !seen; k++) begin
            @(negedge clk);
            n++;
            if (!mem_cs_n) seen = 1;
        end
        req_valid = 1'b0;
        chk(n == exp_gap, tag, n, exp_gap);
        seen = 0;
        for (int k = 0; k < 100 && !seen; k++) begin
            @(negedge clk);
            if (ack) seen = 1;
        end
        repeat (int'(fl) + 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle state while reset is applied
        chk(mem_cs_n && mem_rd_n && mem_wr_n && !ack && !mem_doe && rdata == '0,
            "R1 reset state", {mem_cs_n, mem_rd_n, mem_wr_n, ack, mem_doe}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && mem_rd_n && mem_wr_n && !ack && !mem_doe,
            "R1 idle after reset", {mem_cs_n, mem_rd_n, mem_wr_n, ack, mem_doe}, 5'b11100);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: float gap after reads, none after writes
        gap_test(1'b0, 4'd4, 5, "R9 float gap read F=4");
        gap_test(1'b0, 4'd0, 1, "R9 float gap read F=0");
        gap_test(1'b1, 4'd6, 1, "R9 float not applied to write");

        // R1: reset in the middle of a long access
        @(negedge clk);
        req_write = 1'b1; req_wide = 1'b1; cfg_setup = 6'h02; cfg_pulse = 7'h05;
        cfg_cycle = 9'h1FF; cfg_float = 4'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!mem_wr_n, "R1 strobe active before reset", int'(mem_wr_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && mem_rd_n && mem_wr_n && !ack && !mem_doe,
            "R1 reset aborts access", {mem_cs_n, mem_rd_n, mem_wr_n, ack, mem_doe}, 5'b11100);
        rst_n = 1'b1;
        run_vec(VECS[0]);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule